// File: doc/BRIEF.md
# Three-Input Median Selector Cell

This cell receives three unsigned sample words in one cycle and returns the middle one of the three. It does not use a sorting network. It computes exactly three magnitude comparisons in a ring: first word against second, second against third, third against first. For each input, a two-term sum-of-products over those comparison bits then decides whether that input is the median. The decision is an active-low select per input, and the selects route exactly one word to the median output.

With the extended variant enabled, the same comparison bits also drive separate largest and smallest selects. The cell then returns maximum, median and minimum together, so several cells can be chained to build a sort. A one-cycle valid pipeline registers all results. The cell also reports which input was taken as the median, as a one-hot field.

Top module: `med3_cell`

## Requirements
- R1: After a synchronous active-low reset, `valid_out` is 0 and `med_out`, `max_out`, `min_out` and `med_pick` are all 0.
- R2: For three distinct unsigned inputs, `med_out` equals the middle value, for every one of the six orderings of the inputs.
- R3: With `EXTENDED`=1, `max_out` and `min_out` carry the largest and smallest input of the same sample as `med_out`, so `max_out` >= `med_out` >= `min_out` whenever `valid_out` is 1.
- R4: `med_pick` is one-hot and names the input routed to `med_out`: bit 0 is `in_a`, bit 1 is `in_b`, bit 2 is `in_c`.
- R5: Equal inputs are ranked as if `in_a` were above `in_b` and `in_b` above `in_c`. So all three equal gives `med_pick`=3'b010. `in_a`=`in_b`>`in_c` gives 3'b010. `in_a`=`in_b`<`in_c` gives 3'b001. Exactly one select is active in every case.
- R6: Results appear one clock after the sample is accepted, and `valid_out` equals `valid_in` delayed by one cycle.
- R7: In a cycle with `valid_in` low, the inputs are ignored and all data outputs keep their previous values.
- R8: The comparisons are unsigned over the full range, including the extremes 0 and 2^W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Sample valid; the three words are accepted on this edge |
| in_a | input | W | First sample word |
| in_b | input | W | Second sample word |
| in_c | input | W | Third sample word |
| valid_out | output | 1 | Registered results are valid |
| med_out | output | W | Median of the accepted sample |
| max_out | output | W | Largest word (0 when EXTENDED=0) |
| min_out | output | W | Smallest word (0 when EXTENDED=0) |
| med_pick | output | 3 | One-hot index of the input taken as median |

## Verification
The bench builds the cell with its defaults, W=8 and EXTENDED=1. With 8-bit words, the extremes 0 and 255 are cheap to drive, which exercises unsigned compare wrap hazards. The extended outputs let every test check max, median and min of the same sample together. Repeated-value patterns reach each branch of the tie-break ring, including the all-equal case.

// File: rtl/med3_pkg.sv
// Package: shared constants and types for the three-input median cell.
// Assumes exactly three inputs; the ring comparison scheme depends on it.
package med3_pkg;
    localparam int unsigned NUM_IN = 3;
    typedef logic [NUM_IN-1:0] pick_t;
endpackage

// File: rtl/med3_ring_cmp.sv
// Ring comparator: beat[j] is 1 when input j ranks above input (j+1)%3.
// Ties rank the lower index higher, so the three bits form a strict order.
// Assumes unsigned words.
module med3_ring_cmp
    import med3_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [NUM_IN-1:0][W-1:0] words,
    output pick_t                    beat
);
    for (genvar j = 0; j < NUM_IN; j++) begin : g_cmp
        localparam int unsigned K = (j + 1) % NUM_IN;
        if (j < K) begin : g_lo_first
            // purpose: lower index wins ties against the next input
            assign beat[j] = (words[j] >= words[K]);
        end else begin : g_wrap
            // purpose: the wrapped pair must be strictly greater to win
            assign beat[j] = (words[j] > words[K]);
        end
    end
endmodule

// File: rtl/med3_decide.sv
// Decision logic: per input, a two-product AND-OR over the ring bits gives
// active-low median, max and min selects. Assumes beat[] is a strict order.
module med3_decide
    import med3_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pick_t beat,
    output pick_t med_sel_n,
    output pick_t max_sel_n,
    output pick_t min_sel_n
);
    for (genvar j = 0; j < NUM_IN; j++) begin : g_sel
        localparam int unsigned P = (j + NUM_IN - 1) % NUM_IN;
        // purpose: input j sits between its ring neighbours
        assign med_sel_n[j] = ~((beat[j] & beat[P]) | (~beat[j] & ~beat[P]));
        if (EXTENDED) begin : g_ext
            // purpose: input j beats both neighbours / loses to both
            assign max_sel_n[j] = ~(beat[j] & ~beat[P]);
            assign min_sel_n[j] = ~(~beat[j] & beat[P]);
        end else begin : g_base
            assign max_sel_n[j] = 1'b1;
            assign min_sel_n[j] = 1'b1;
        end
    end

    AST_MED_SEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~med_sel_n) == 1); // R5
    if (EXTENDED) begin : g_ast_ext
        AST_MAX_SEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(~max_sel_n) == 1); // R3
        AST_MIN_SEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(~min_sel_n) == 1); // R3
    end
endmodule

// File: rtl/med3_route.sv
// Routing and output stage: the active-low selects gate words onto the
// outputs, which are registered when a sample is accepted.
// Assumes each select vector has exactly one low bit.
module med3_route
    import med3_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_in,
    input  logic [NUM_IN-1:0][W-1:0] words,
    input  pick_t                    med_sel_n,
    input  pick_t                    max_sel_n,
    input  pick_t                    min_sel_n,
    output logic                     valid_q,
    output logic [W-1:0]             med_q,
    output logic [W-1:0]             max_q,
    output logic [W-1:0]             min_q,
    output pick_t                    pick_q
);
    logic [W-1:0] med_d, max_d, min_d;

    // purpose: AND-OR gating of each word by its active-low select
    always_comb begin
        med_d = '0;
        max_d = '0;
        min_d = '0;
        for (int j = 0; j < NUM_IN; j++) begin
            med_d = med_d | (words[j] & {W{~med_sel_n[j]}});
            max_d = max_d | (words[j] & {W{~max_sel_n[j]}});
            min_d = min_d | (words[j] & {W{~min_sel_n[j]}});
        end
    end

    // purpose: valid pipeline stage, follows valid_in every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_in;
    end

    // purpose: result registers, load on accepted sample, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            med_q  <= '0;
            max_q  <= '0;
            min_q  <= '0;
            pick_q <= '0;
        end else if (valid_in) begin
            med_q  <= med_d;
            max_q  <= max_d;
            min_q  <= min_d;
            pick_q <= ~med_sel_n;
        end
    end

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_q); // R6
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_q); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(med_q) && $stable(max_q) && $stable(min_q))); // R7
endmodule

// File: rtl/med3_cell.sv
// Top: three-input median cell with optional max/min outputs.
// Assumes unsigned words; one-cycle latency from valid_in to valid_out.
module med3_cell
    import med3_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter bit          EXTENDED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_in,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic         valid_out,
    output logic [W-1:0] med_out,
    output logic [W-1:0] max_out,
    output logic [W-1:0] min_out,
    output logic [2:0]   med_pick
);
    logic [NUM_IN-1:0][W-1:0] words;
    pick_t beat, med_sel_n, max_sel_n, min_sel_n;

    assign words = {in_c, in_b, in_a};

    med3_ring_cmp #(.W(W)) u_cmp (.words(words), .beat(beat));

    med3_decide #(.EXTENDED(EXTENDED)) u_dec (
        .clk(clk), .rst_n(rst_n), .beat(beat),
        .med_sel_n(med_sel_n), .max_sel_n(max_sel_n), .min_sel_n(min_sel_n)
    );

    med3_route #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .words(words),
        .med_sel_n(med_sel_n), .max_sel_n(max_sel_n), .min_sel_n(min_sel_n),
        .valid_q(valid_out), .med_q(med_out), .max_q(max_out),
        .min_q(min_out), .pick_q(med_pick)
    );

    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> $onehot0(med_pick) && (med_pick != 3'b000)); // R4
    if (EXTENDED) begin : g_ast_order
        AST_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
            valid_out |-> (max_out >= med_out) && (med_out >= min_out)); // R3
    end
endmodule

// File: tb/med3_cell_bench.sv
module med3_cell_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0, in_c = '0;
    logic         valid_out;
    logic [W-1:0] med_out, max_out, min_out;
    logic [2:0]   med_pick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    med3_cell #(.W(W), .EXTENDED(1'b1)) u_med3_cell (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .valid_out(valid_out), .med_out(med_out), .max_out(max_out),
        .min_out(min_out), .med_pick(med_pick)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ranking from the requirements: larger value first, ties by lower index
    function automatic bit ranks_above(int i, int j, logic [W-1:0] v[3]);
        return (v[i] > v[j]) || ((v[i] == v[j]) && (i < j));
    endfunction

    task automatic apply_check(string req, logic [W-1:0] a, logic [W-1:0] b,
                               logic [W-1:0] c);
        logic [W-1:0] v[3];
        logic [W-1:0] e_med, e_max, e_min;
        logic [2:0]   e_pick;
        v[0] = a; v[1] = b; v[2] = c;
        e_med = '0; e_max = '0; e_min = '0; e_pick = '0;
        for (int i = 0; i < 3; i++) begin
            int above = 0;
            for (int j = 0; j < 3; j++)
                if (j != i && ranks_above(j, i, v)) above++;
            if (above == 0) e_max = v[i];
            if (above == 1) begin e_med = v[i]; e_pick[i] = 1'b1; end
            if (above == 2) e_min = v[i];
        end
        @(negedge clk);
        valid_in = 1'b1; in_a = a; in_b = b; in_c = c;
        @(negedge clk);
        valid_in = 1'b0;
        check({req, " R6 valid"}, 32'(valid_out), 32'd1);
        check({req, " R2 med"}, 32'(med_out), 32'(e_med));
        check({req, " R3 max"}, 32'(max_out), 32'(e_max));
        check({req, " R3 min"}, 32'(min_out), 32'(e_min));
        check({req, " R4 pick"}, 32'(med_pick), 32'(e_pick));
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 valid_out", 32'(valid_out), 0);
        check("R1 med_out", 32'(med_out), 0);
        check("R1 max_out", 32'(max_out), 0);
        check("R1 min_out", 32'(min_out), 0);
        check("R1 med_pick", 32'(med_pick), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_orderings();
        apply_check("R2 abc", 8'd30, 8'd20, 8'd10);
        apply_check("R2 acb", 8'd30, 8'd10, 8'd20);
        apply_check("R2 bac", 8'd20, 8'd30, 8'd10);
        apply_check("R2 bca", 8'd10, 8'd30, 8'd20);
        apply_check("R2 cab", 8'd20, 8'd10, 8'd30);
        apply_check("R2 cba", 8'd10, 8'd20, 8'd30);
    endtask

    task automatic test_ties();
        apply_check("R5 all_eq", 8'd77, 8'd77, 8'd77);
        apply_check("R5 ab_hi", 8'd50, 8'd50, 8'd5);
        check("R5 pick ab_hi", 32'(med_pick), 32'h2);
        apply_check("R5 ab_lo", 8'd5, 8'd5, 8'd50);
        check("R5 pick ab_lo", 32'(med_pick), 32'h1);
        apply_check("R5 bc_hi", 8'd1, 8'd9, 8'd9);
        apply_check("R5 ca_lo", 8'd3, 8'd9, 8'd3);
        apply_check("R5 ca_hi", 8'd9, 8'd3, 8'd9);
    endtask

    task automatic test_extremes();
        apply_check("R8 0_max_mid", 8'd0, 8'd255, 8'd128);
        apply_check("R8 max_0_1", 8'd255, 8'd0, 8'd1);
        apply_check("R8 254_255_0", 8'd254, 8'd255, 8'd0);
    endtask

    task automatic test_hold();
        apply_check("R7 load", 8'd40, 8'd60, 8'd50);
        @(negedge clk);
        in_a = 8'd1; in_b = 8'd2; in_c = 8'd3;
        @(negedge clk);
        check("R7 valid low", 32'(valid_out), 0);
        check("R7 med held", 32'(med_out), 32'd50);
        check("R7 max held", 32'(max_out), 32'd60);
        check("R7 min held", 32'(min_out), 32'd40);
        check("R7 pick held", 32'(med_pick), 32'h4);
    endtask

    task automatic test_stream();
        // back-to-back samples: each result lands exactly one cycle later
        @(negedge clk);
        valid_in = 1'b1; in_a = 8'd9; in_b = 8'd1; in_c = 8'd5;
        @(negedge clk);
        check("R6 stream1 med", 32'(med_out), 32'd5);
        in_a = 8'd100; in_b = 8'd200; in_c = 8'd150;
        @(negedge clk);
        valid_in = 1'b0;
        check("R6 stream2 med", 32'(med_out), 32'd150);
        check("R6 stream2 valid", 32'(valid_out), 1);
        @(negedge clk);
        check("R6 stream drop", 32'(valid_out), 0);
    endtask

    initial begin
        test_reset();
        test_orderings();
        test_ties();
        test_extremes();
        test_hold();
        test_stream();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule